// File: doc/BRIEF.md
# SPI Host Segment Sequencer

This block runs the byte-level side of a SPI host controller. Software writes a command word that describes one transfer segment, and the sequencer then exchanges the requested number of bytes. For each byte it takes the next transmit byte from an internal TX byte FIFO and hands it to a serial shifter through a request/acknowledge handshake. It stores the byte that comes back in an internal RX byte FIFO. Bit shifting and clock division sit in the shifter, outside this block.

A segment is accepted only while the host reports itself ready and the block is enabled. The segment stops early if the TX FIFO runs dry or the RX FIFO has no room. Each of these conditions leaves a sticky stall flag. When a segment ends, for any reason, the TX bytes it did not use are discarded.

The block also holds a chip-select ID register and one configuration word per chip select. Reads and writes of the configuration word go to the entry that the current ID selects. A soft-reset strobe brings every register and both FIFOs back to their reset state.

Top module: `spi_seg_seq`

## Requirements
- R1: The segment length is bits 7:0 of the command word, and the other command bits do not change how many bytes are exchanged. For each byte, the oldest TX FIFO byte appears on `xfer_tx`, and `xfer_req` stays high with `xfer_tx` unchanged until a cycle in which `xfer_ack` is high.
- R2: The `xfer_rx` value sampled with each acknowledge is written to the RX FIFO. The RX FIFO shows its oldest byte on `rx_byte` without a read delay, and `rx_pop` moves to the next byte.
- R3: Accepting a command drops `ready` and raises `active` on the clock edge that takes the write. Both stay that way until the segment ends. `ready` and `active` are never high together, and `xfer_req` is high only while `active` is high.
- R4: A command written while `ready` is high and `ctl_en` is low is stored in `cmd_q`. It starts no transfer, and `ready` stays high.
- R5: A command written while `ready` is low sets the sticky `err_cmdbusy` flag and leaves `cmd_q` and the running segment unchanged.
- R6: If the TX FIFO is empty before a byte with bytes still to go, `tx_stall` is set and the segment ends. Both stall flags clear when the next command is accepted.
- R7: If the RX FIFO is full before a byte with bytes still to go, `rx_stall` is set and the segment ends. The RX FIFO never holds more than its depth.
- R8: When a segment ends, `ready` returns high and the TX FIFO is emptied, so `tx_empty` is 1 and `tx_full` is 0.
- R9: A command with a length of zero starts no exchange. `ready` is low for exactly one cycle and is high again after the second clock edge that follows the write.
- R10: A chip-select ID write with a value of at least `NUM_CS` sets the sticky `err_csid_inval` flag and leaves `csid_q` unchanged. A smaller value is stored.
- R11: A configuration write goes to the entry selected by `csid_q`. `cfg_rdata` shows the entry for the current `csid_q` one cycle after the ID or the entry changes.
- R12: A high `ctl_srst` resets the block on the next clock edge, as `rst` does. The ID and all configuration words go to 0, both error flags and both stall flags clear, both FIFOs empty, `ready` is 1, `active` is 0, and any running segment is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Enable; commands start segments only while high |
| ctl_srst | input | 1 | Soft-reset strobe |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | CMD_W | Command word (length in bits 7:0) |
| cmd_q | output | CMD_W | Last stored command word |
| csid_we | input | 1 | Chip-select ID write strobe |
| csid_wdata | input | CSID_W | Chip-select ID write value |
| csid_q | output | CSID_W | Current chip-select ID |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | CFG_W | Configuration write value |
| cfg_rdata | output | CFG_W | Configuration word of the current chip select |
| tx_push | input | 1 | Write one byte into the TX FIFO (ignored when full) |
| tx_byte | input | 8 | Byte to write |
| tx_full | output | 1 | TX FIFO full |
| tx_empty | output | 1 | TX FIFO empty |
| tx_level | output | TX_LW | TX FIFO fill count |
| rx_pop | input | 1 | Remove the oldest RX byte (ignored when empty) |
| rx_byte | output | 8 | Oldest RX byte |
| rx_full | output | 1 | RX FIFO full |
| rx_empty | output | 1 | RX FIFO empty |
| rx_level | output | RX_LW | RX FIFO fill count |
| xfer_req | output | 1 | Byte exchange request to the shifter |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | Shifter finished the byte |
| xfer_rx | input | 8 | Byte shifted in |
| ready | output | 1 | Ready for a new command |
| active | output | 1 | Segment in progress |
| tx_stall | output | 1 | Last segment ended on an empty TX FIFO |
| rx_stall | output | 1 | Last segment ended on a full RX FIFO |
| err_cmdbusy | output | 1 | Sticky: command written while not ready |
| err_csid_inval | output | 1 | Sticky: out-of-range chip-select ID written |

## Verification
The bench targets the places where a segment can end early or end wrong. These are a length shorter than the queued TX bytes, where a design that does not flush would leak stale bytes into the next segment. They also include a length longer than the queued bytes, where a design without the empty check would send garbage, and an RX FIFO that is already full, where a design without the check would overwrite data that has not been read. It sends a zero-length command, which a design with an off-by-one counter would turn into 256 exchanges. It writes a command while a segment is running, which a design that does not check would restart or corrupt. It also writes an out-of-range chip-select ID, which would otherwise point the configuration access at a missing entry. Finally, it asserts a soft reset in the middle of a segment to confirm that all state returns to its reset values.

// File: rtl/spi_seg_pkg.sv
package spi_seg_pkg;
  localparam int CMD_W   = 14;
  localparam int LEN_W   = 8;
  localparam int LEN_LSB = 0;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CHECK = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;

  function automatic logic [LEN_W-1:0] cmd_len(input logic [CMD_W-1:0] w);
    return w[LEN_LSB +: LEN_W];
  endfunction
endpackage

// File: rtl/seg_byte_fifo.sv
module seg_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   level
);
  localparam logic [AW:0] LVL_MAX = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         do_push, do_pop;

  assign level   = wptr - rptr;
  assign empty   = (level == '0);
  assign full    = (level == LVL_MAX);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr[AW-1:0]];

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/seg_cs_regs.sv
module seg_cs_regs #(
  parameter int NUM_CS = 4,
  parameter int CFG_W  = 32,
  parameter int CSID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csid_we,
  input  logic [CSID_W-1:0] csid_wdata,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CSID_W-1:0] csid_q,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              err_csid
);
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam logic [CSID_W-1:0] CS_LIMIT = CSID_W'(NUM_CS);

  logic [CFG_W-1:0] cfg_q [NUM_CS];

  always_ff @(posedge clk) begin
    if (rst) begin
      csid_q   <= '0;
      err_csid <= 1'b0;
    end else if (csid_we) begin
      if (csid_wdata < CS_LIMIT) csid_q <= csid_wdata;
      else                       err_csid <= 1'b1;
    end
  end

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst)                                         cfg_q[gi] <= '0;
      else if (cfg_we && (csid_q == CSID_W'(gi)))      cfg_q[gi] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= cfg_q[csid_q[IDX_W-1:0]];
  end
endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
  import spi_seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_q,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_rdata,
  input  logic              rx_full,
  output logic              tx_pop,
  output logic              tx_flush,
  input  logic              xfer_ack,
  output logic              rx_push,
  output logic              xfer_req,
  output logic [BYTE_W-1:0] xfer_tx,
  output logic              ready,
  output logic              active,
  output logic              tx_stall,
  output logic              rx_stall,
  output logic              err_cmdbusy
);
  seq_state_e       state;
  logic [LEN_W-1:0] remain;
  logic             at_check, none_left, seg_end;

  assign at_check  = (state == SQ_CHECK);
  assign none_left = (remain == '0);
  assign seg_end   = at_check && (none_left || tx_empty || rx_full);
  assign tx_pop    = at_check && !none_left && !tx_empty && !rx_full;
  assign tx_flush  = seg_end;
  assign rx_push   = (state == SQ_WAIT) && xfer_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      remain      <= '0;
      ready       <= 1'b1;
      active      <= 1'b0;
      xfer_req    <= 1'b0;
      xfer_tx     <= '0;
      tx_stall    <= 1'b0;
      rx_stall    <= 1'b0;
      err_cmdbusy <= 1'b0;
      cmd_q       <= '0;
    end else begin
      if (cmd_we && !ready) err_cmdbusy <= 1'b1;
      unique case (state)
        SQ_IDLE: begin
          if (cmd_we && ready) begin
            cmd_q <= cmd_wdata;
            if (en) begin
              ready    <= 1'b0;
              active   <= 1'b1;
              remain   <= cmd_len(cmd_wdata);
              tx_stall <= 1'b0;
              rx_stall <= 1'b0;
              state    <= SQ_CHECK;
            end
          end
        end
        SQ_CHECK: begin
          if (seg_end) begin
            if (!none_left && tx_empty)      tx_stall <= 1'b1;
            else if (!none_left && rx_full)  rx_stall <= 1'b1;
            ready  <= 1'b1;
            active <= 1'b0;
            state  <= SQ_IDLE;
          end else begin
            xfer_tx  <= tx_rdata;
            xfer_req <= 1'b1;
            state    <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (xfer_ack) begin
            xfer_req <= 1'b0;
            remain   <= remain - 1'b1;
            state    <= SQ_CHECK;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_seg_seq.sv
module spi_seg_seq
  import spi_seg_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int NUM_CS   = 4,
  parameter int CFG_W    = 32,
  parameter int CSID_W   = 8,
  localparam int TX_LW   = ((TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1) + 1,
  localparam int RX_LW   = ((RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_en,
  input  logic              ctl_srst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_q,
  input  logic              csid_we,
  input  logic [CSID_W-1:0] csid_wdata,
  output logic [CSID_W-1:0] csid_q,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              tx_push,
  input  logic [7:0]        tx_byte,
  output logic              tx_full,
  output logic              tx_empty,
  output logic [TX_LW-1:0]  tx_level,
  input  logic              rx_pop,
  output logic [7:0]        rx_byte,
  output logic              rx_full,
  output logic              rx_empty,
  output logic [RX_LW-1:0]  rx_level,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              ready,
  output logic              active,
  output logic              tx_stall,
  output logic              rx_stall,
  output logic              err_cmdbusy,
  output logic              err_csid_inval
);
  logic rst_all;
  logic tx_pop, tx_flush, rx_push;
  logic [7:0] tx_head;

  // soft reset acts as a second synchronous reset source
  assign rst_all = rst || ctl_srst;

  seg_byte_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst(rst_all), .flush(tx_flush),
    .push(tx_push), .din(tx_byte),
    .pop(tx_pop), .dout(tx_head),
    .empty(tx_empty), .full(tx_full), .level(tx_level)
  );

  seg_byte_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst(rst_all), .flush(1'b0),
    .push(rx_push), .din(xfer_rx),
    .pop(rx_pop), .dout(rx_byte),
    .empty(rx_empty), .full(rx_full), .level(rx_level)
  );

  seg_cs_regs #(.NUM_CS(NUM_CS), .CFG_W(CFG_W), .CSID_W(CSID_W)) u_cs (
    .clk(clk), .rst(rst_all),
    .csid_we(csid_we), .csid_wdata(csid_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .csid_q(csid_q), .cfg_rdata(cfg_rdata), .err_csid(err_csid_inval)
  );

  seg_sequencer u_seq (
    .clk(clk), .rst(rst_all), .en(ctl_en),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
    .tx_empty(tx_empty), .tx_rdata(tx_head), .rx_full(rx_full),
    .tx_pop(tx_pop), .tx_flush(tx_flush),
    .xfer_ack(xfer_ack), .rx_push(rx_push),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .ready(ready), .active(active),
    .tx_stall(tx_stall), .rx_stall(rx_stall), .err_cmdbusy(err_cmdbusy)
  );
endmodule

// File: rtl/seg_seq_checker.sv
module seg_seq_checker #(
  parameter int RX_DEPTH = 8,
  parameter int NUM_CS   = 4,
  parameter int CMD_W    = 14,
  parameter int CSID_W   = 8,
  parameter int RX_LW    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_en,
  input logic              ctl_srst,
  input logic              cmd_we,
  input logic [CMD_W-1:0]  cmd_q,
  input logic              csid_we,
  input logic [CSID_W-1:0] csid_wdata,
  input logic [CSID_W-1:0] csid_q,
  input logic              ready,
  input logic              active,
  input logic              xfer_req,
  input logic              xfer_ack,
  input logic [7:0]        xfer_tx,
  input logic              tx_empty,
  input logic              rx_empty,
  input logic [RX_LW-1:0]  rx_level,
  input logic              err_cmdbusy,
  input logic              err_csid_inval
);
  assert_ready_active_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(ready && active));

  assert_req_in_segment_R3: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> active);

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack && !ctl_srst) |=> (xfer_req && $stable(xfer_tx)));

  assert_disabled_no_start_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && ready && !ctl_en && !ctl_srst) |=> (ready && !active));

  assert_busy_cmd_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !ready && !ctl_srst) |=> (err_cmdbusy && $stable(cmd_q)));

  assert_rx_bound_R7: assert property (@(posedge clk) disable iff (rst)
    rx_level <= RX_LW'(RX_DEPTH));

  assert_bad_csid_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (csid_we && (csid_wdata >= CSID_W'(NUM_CS)) && !ctl_srst)
      |=> (err_csid_inval && $stable(csid_q)));

  assert_soft_reset_state_R12: assert property (@(posedge clk) disable iff (rst)
    ctl_srst |=> (ready && !active && tx_empty && rx_empty && !err_cmdbusy
                  && !err_csid_inval && (csid_q == '0)));
endmodule

bind spi_seg_seq seg_seq_checker #(
  .RX_DEPTH(RX_DEPTH), .NUM_CS(NUM_CS), .CMD_W(spi_seg_pkg::CMD_W),
  .CSID_W(CSID_W), .RX_LW(RX_LW)
) u_chk (
  .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_srst(ctl_srst),
  .cmd_we(cmd_we), .cmd_q(cmd_q),
  .csid_we(csid_we), .csid_wdata(csid_wdata), .csid_q(csid_q),
  .ready(ready), .active(active),
  .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_tx(xfer_tx),
  .tx_empty(tx_empty), .rx_empty(rx_empty), .rx_level(rx_level),
  .err_cmdbusy(err_cmdbusy), .err_csid_inval(err_csid_inval)
);

// File: tb/test_spi_seg_seq.sv
`timescale 1ns/1ps
module test_spi_seg_seq;
  localparam int CMDW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_en = 1'b0, ctl_srst = 1'b0;
  logic cmd_we = 1'b0;
  logic [CMDW-1:0] cmd_wdata = '0;
  logic [CMDW-1:0] cmd_q;
  logic csid_we = 1'b0;
  logic [7:0] csid_wdata = '0;
  logic [7:0] csid_q;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic tx_push = 1'b0;
  logic [7:0] tx_byte = '0;
  logic tx_full, tx_empty;
  logic [3:0] tx_level;
  logic rx_pop = 1'b0;
  logic [7:0] rx_byte;
  logic rx_full, rx_empty;
  logic [3:0] rx_level;
  logic xfer_req;
  logic [7:0] xfer_tx;
  logic xfer_ack = 1'b0;
  logic [7:0] xfer_rx = '0;
  logic ready, active, tx_stall, rx_stall, err_cmdbusy, err_csid_inval;

  int checks = 0;
  int fails = 0;
  int xcount = 0;
  int dly = 0;
  bit done = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];

  always #10 clk = ~clk;

  spi_seg_seq i_spi_seg_seq (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_srst(ctl_srst),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
    .csid_we(csid_we), .csid_wdata(csid_wdata), .csid_q(csid_q),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_push(tx_push), .tx_byte(tx_byte), .tx_full(tx_full),
    .tx_empty(tx_empty), .tx_level(tx_level),
    .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_full(rx_full),
    .rx_empty(rx_empty), .rx_level(rx_level),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .ready(ready), .active(active), .tx_stall(tx_stall), .rx_stall(rx_stall),
    .err_cmdbusy(err_cmdbusy), .err_csid_inval(err_csid_inval)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // shifter model and scoreboard monitor: compares each byte sent (R1) and
  // queues the reply byte for the RX side (R2)
  always @(negedge clk) begin
    xfer_ack = 1'b0;
    if (xfer_req && !rst && !ctl_srst) begin
      dly++;
      if (dly == 2) begin
        dly = 0;
        if (exp_tx.size() == 0) chk(1'b0, "R1 unexpected byte", xfer_tx, 0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          chk(xfer_tx == e, "R1 tx byte", xfer_tx, e);
        end
        xfer_rx = xfer_tx ^ 8'h5A;
        exp_rx.push_back(xfer_tx ^ 8'h5A);
        xfer_ack = 1'b1;
        xcount++;
      end
    end else dly = 0;
  end

  task automatic push_tx(input logic [7:0] b, input bit expect_sent);
    @(negedge clk);
    tx_push = 1'b1; tx_byte = b;
    if (expect_sent) exp_tx.push_back(b);
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic send_cmd(input logic [CMDW-1:0] w);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 300 && !ready; i++) @(negedge clk);
    chk(ready, "R8 ready after segment", ready, 1);
  endtask

  task automatic pop_check(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      @(negedge clk);
      e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 8'hxx;
      chk(!rx_empty && rx_byte == e, req, rx_byte, e);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
    end
  endtask

  task automatic wr_csid(input logic [7:0] v);
    @(negedge clk); csid_we = 1'b1; csid_wdata = v;
    @(negedge clk); csid_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int x0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R12 values)
    chk(ready && !active && tx_empty && rx_empty, "R12 reset flags", {ready, active, tx_empty, rx_empty}, 4'b1011);
    chk(csid_q == 0 && !err_cmdbusy && !err_csid_inval, "R12 reset regs", csid_q, 0);

    // R11 / R10: per chip-select configuration words
    wr_cfg(32'hCAFE_0000);
    wr_csid(8'd1);
    wr_cfg(32'h1234_5678);
    chk(cfg_rdata == 32'h1234_5678, "R11 cfg entry 1", cfg_rdata, 32'h1234_5678);
    wr_csid(8'd0);
    @(negedge clk);
    chk(cfg_rdata == 32'hCAFE_0000, "R11 cfg entry 0", cfg_rdata, 32'hCAFE_0000);
    wr_csid(8'd1);
    wr_csid(8'd4);
    chk(err_csid_inval && csid_q == 8'd1, "R10 bad csid", csid_q, 1);
    chk(cfg_rdata == 32'h1234_5678, "R10 cfg after bad csid", cfg_rdata, 32'h1234_5678);

    // R4: disabled command stored, no transfer
    send_cmd(14'h0003);
    chk(cmd_q == 14'h0003 && ready && !active, "R4 disabled cmd", cmd_q, 3);
    repeat (10) @(negedge clk);
    chk(xcount == 0, "R4 no exchange", xcount, 0);

    // R1/R2/R3: main segment, upper command bits set
    ctl_en = 1'b1;
    x0 = xcount;
    push_tx(8'h11, 1); push_tx(8'h22, 1); push_tx(8'h33, 1); push_tx(8'h44, 1);
    send_cmd(14'h3204);
    chk(!ready && active, "R3 accept flags", {ready, active}, 2'b01);
    wait_ready();
    chk(xcount - x0 == 4 && rx_level == 4, "R1 length from bits 7:0", xcount - x0, 4);
    chk(!tx_stall && !rx_stall, "R6 no stall", {tx_stall, rx_stall}, 0);
    pop_check(4, "R2 rx order");

    // R5: command while busy
    x0 = xcount;
    push_tx(8'hA1, 1); push_tx(8'hA2, 1); push_tx(8'hA3, 1); push_tx(8'hA4, 1);
    send_cmd(14'h0004);
    send_cmd(14'h00AB);
    chk(err_cmdbusy && cmd_q == 14'h0004, "R5 busy cmd", cmd_q, 4);
    wait_ready();
    chk(xcount - x0 == 4, "R5 segment unaffected", xcount - x0, 4);
    pop_check(4, "R2 rx after busy");

    // R8: leftover TX bytes flushed, TX was full
    x0 = xcount;
    for (int i = 0; i < 8; i++) push_tx(8'h60 + 8'(i), i < 2);
    chk(tx_full, "R8 tx full before", tx_full, 1);
    send_cmd(14'h0002);
    wait_ready();
    chk(tx_empty && !tx_full && tx_level == 0, "R8 flush", tx_level, 0);
    chk(xcount - x0 == 2, "R8 exchanged count", xcount - x0, 2);
    pop_check(2, "R2 rx after flush");

    // R6: TX runs dry
    x0 = xcount;
    push_tx(8'h71, 1); push_tx(8'h72, 1);
    send_cmd(14'h0005);
    wait_ready();
    chk(tx_stall && !rx_stall, "R6 tx stall", {tx_stall, rx_stall}, 2'b10);
    chk(xcount - x0 == 2, "R6 exchanged count", xcount - x0, 2);
    pop_check(2, "R2 rx after stall");

    // R7: RX full blocks next segment
    for (int i = 0; i < 8; i++) push_tx(8'h80 + 8'(i), 1);
    send_cmd(14'h0008);
    wait_ready();
    chk(rx_full && rx_level == 8, "R7 rx filled", rx_level, 8);
    x0 = xcount;
    push_tx(8'h91, 0); push_tx(8'h92, 0); push_tx(8'h93, 0);
    send_cmd(14'h0003);
    wait_ready();
    chk(rx_stall && !tx_stall, "R7 rx stall, R6 stall clear", {tx_stall, rx_stall}, 2'b01);
    chk(xcount == x0 && tx_empty && rx_level == 8, "R7 nothing exchanged", xcount - x0, 0);
    pop_check(8, "R7 rx data kept");

    // R9: zero length
    x0 = xcount;
    push_tx(8'hEE, 0);
    send_cmd(14'h0000);
    chk(!ready, "R9 ready low one cycle", ready, 0);
    @(negedge clk);
    chk(ready && !active, "R9 ready back", ready, 1);
    chk(xcount == x0 && tx_empty, "R9 no exchange", xcount - x0, 0);

    // R12: soft reset mid-segment
    wr_csid(8'd2);
    wr_cfg(32'h0BAD_F00D);
    push_tx(8'hC1, 0); push_tx(8'hC2, 0); push_tx(8'hC3, 0); push_tx(8'hC4, 0);
    send_cmd(14'h0004);
    chk(active, "R12 segment running", active, 1);
    ctl_srst = 1'b1;
    @(negedge clk);
    ctl_srst = 1'b0;
    exp_tx.delete();
    chk(ready && !active && tx_empty && rx_empty, "R12 srst flags", {ready, active, tx_empty, rx_empty}, 4'b1011);
    chk(csid_q == 0 && !err_cmdbusy && !err_csid_inval && !tx_stall && !rx_stall, "R12 srst regs", csid_q, 0);
    @(negedge clk);
    chk(cfg_rdata == 0, "R12 cfg cleared", cfg_rdata, 0);
    wr_csid(8'd1);
    chk(cfg_rdata == 0, "R12 cfg entry 1 cleared", cfg_rdata, 0);
    repeat (5) @(negedge clk);
    chk(!xfer_req, "R12 no request after srst", xfer_req, 0);

    finish_run();
  end
endmodule